// File: doc/BRIEF.md
# Next-PC Fetch and Branch Unit

This block owns the program counter of a small 32-bit load/store core whose instruction memory is byte addressed and returns a word in the same cycle it is addressed. The program counter drives the fetch address directly. The word that comes back is latched into a 32-bit instruction register on every enabled clock edge. The same word also supplies the branch offset and the jump field used to compute the next program counter in that cycle.

Four candidates compete for the next program counter. The first is the sequential address, PC + 4. The second is a PC-relative branch target, formed from PC + 4 plus four times the signed 16-bit offset. The third is a region-local jump target, built from the upper four bits of PC + 4 placed above the 26-bit word field shifted left by two. The fourth is a full 32-bit register operand. The decode stage outside this block supplies a branch-on-equal line, an absolute-jump line and a register-jump line, and the ALU supplies its zero flag. An enable input stalls the whole fetch.

Top module: `fetch_pc_unit`

## Requirements
- R1: An active-high synchronous reset sets the program counter to 0x00000000 and the instruction register to all zeros (a NOP) on the next rising edge.
- R2: While `fetch_en` is low, a rising edge changes neither the program counter nor the instruction register, whatever the select lines carry.
- R3: With `fetch_en` high and no select line active, the next program counter is PC + 4.
- R4: With `br_eq` and `alu_zero` both high, the next program counter is PC + 4 + 4 × offset. The offset is bits 15:0 of the fetched word, read as two's complement, so negative offsets move backwards.
- R5: A branch is not taken when either `br_eq` or `alu_zero` is low, and the program counter then advances by 4.
- R6: With `jump_abs` high, the next program counter is bits 31:28 of PC + 4, followed by bits 25:0 of the fetched word, followed by two zero bits.
- R7: With `jump_reg` high, the next program counter is the full 32-bit `reg_target` value.
- R8: When several selects are active, `jump_reg` wins over `jump_abs`, `jump_abs` wins over a taken branch, and a taken branch wins over PC + 4.
- R9: On an enabled edge outside reset, the instruction register captures the word that memory returned for the current program counter.
- R10: `imem_addr` always equals the current program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Advances PC and instruction register when high |
| br_eq | input | 1 | Conditional-branch instruction in flight |
| alu_zero | input | 1 | ALU result was zero (compared operands equal) |
| jump_abs | input | 1 | Region-local absolute jump |
| jump_reg | input | 1 | Register-indirect jump |
| reg_target | input | 32 | Register operand for the register jump |
| imem_rdata | input | 32 | Word returned by instruction memory |
| imem_addr | output | 32 | Fetch byte address (the PC) |
| instr_q | output | 32 | Instruction register |

## Verification
A wrong next-PC choice shows on `imem_addr` one edge after the faulty cycle. From then on every later fetch address is offset, so one compare per clock catches it at once. A sign-extension slip only shows with a negative offset, and a wrong choice of upper-bit source only shows when PC + 4 crosses a 256 MB region boundary. Both cases are driven on purpose. A dropped instruction-register load shows on `instr_q` one edge later, and a stall that leaks shows as an address that moved while `fetch_en` was low.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int XLEN_D   = 32;
  localparam int OFF_W_D  = 16;
  localparam int JFLD_W_D = 26;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_JMP = 2'd2,
    SRC_REG = 2'd3
  } nxt_src_e;
endpackage

// File: rtl/pc_target_calc.sv
module pc_target_calc #(
  parameter int XLEN   = fetch_pkg::XLEN_D,
  parameter int OFF_W  = fetch_pkg::OFF_W_D,
  parameter int JFLD_W = fetch_pkg::JFLD_W_D
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [JFLD_W-1:0] jfield,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   br_pc,
  output logic [XLEN-1:0]   jmp_pc
);
  localparam int RGN_W = XLEN - JFLD_W - 2;
  localparam int EXT_W = XLEN - OFF_W - 2;
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  function automatic logic [XLEN-1:0] f_seq(input logic [XLEN-1:0] p);
    return p + WORD_BYTES;
  endfunction

  function automatic logic [XLEN-1:0] f_branch(input logic [XLEN-1:0] p4,
                                               input logic [OFF_W-1:0] off);
    logic [XLEN-1:0] disp;
    disp = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    return p4 + disp;
  endfunction

  function automatic logic [XLEN-1:0] f_jump(input logic [XLEN-1:0] p4,
                                             input logic [JFLD_W-1:0] jf);
    return {p4[XLEN-1 -: RGN_W], jf, 2'b00};
  endfunction

  always_comb begin
    seq_pc = f_seq(pc);
    br_pc  = f_branch(seq_pc, jfield[OFF_W-1:0]);
    jmp_pc = f_jump(seq_pc, jfield);
  end
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel #(
  parameter int XLEN = fetch_pkg::XLEN_D
) (
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] br_pc,
  input  logic [XLEN-1:0] jmp_pc,
  input  logic [XLEN-1:0] reg_pc,
  input  logic            br_eq,
  input  logic            alu_zero,
  input  logic            jump_abs,
  input  logic            jump_reg,
  output logic            br_taken,
  output logic [XLEN-1:0] nxt_pc
);
  import fetch_pkg::*;
  nxt_src_e src;

  assign br_taken = br_eq & alu_zero;

  always_comb begin
    if (jump_reg)      src = SRC_REG;
    else if (jump_abs) src = SRC_JMP;
    else if (br_taken) src = SRC_BR;
    else               src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_REG: nxt_pc = reg_pc;
      SRC_JMP: nxt_pc = jmp_pc;
      SRC_BR:  nxt_pc = br_pc;
      default: nxt_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/pc_fetch_regs.sv
module pc_fetch_regs #(
  parameter int XLEN = fetch_pkg::XLEN_D
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [XLEN-1:0] nxt_pc,
  input  logic [XLEN-1:0] word,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] ir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
    end else if (en) begin
      pc_q <= nxt_pc;
      ir_q <= word;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pc_q == '0) && (ir_q == '0)); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc_q) && $stable(ir_q)); // R2
  AST_IR_LATCHES: assert property (@(posedge clk) disable iff (rst)
    en |=> ir_q == $past(word)); // R9
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit #(
  parameter int XLEN   = fetch_pkg::XLEN_D,
  parameter int OFF_W  = fetch_pkg::OFF_W_D,
  parameter int JFLD_W = fetch_pkg::JFLD_W_D
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_en,
  input  logic            br_eq,
  input  logic            alu_zero,
  input  logic            jump_abs,
  input  logic            jump_reg,
  input  logic [XLEN-1:0] reg_target,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] imem_addr,
  output logic [XLEN-1:0] instr_q
);
  logic [XLEN-1:0] pc_q, seq_pc, br_pc, jmp_pc, nxt_pc;
  logic            br_taken;

  pc_target_calc #(.XLEN(XLEN), .OFF_W(OFF_W), .JFLD_W(JFLD_W)) u_calc (
    .pc(pc_q), .jfield(imem_rdata[JFLD_W-1:0]),
    .seq_pc(seq_pc), .br_pc(br_pc), .jmp_pc(jmp_pc)
  );

  pc_next_sel #(.XLEN(XLEN)) u_sel (
    .seq_pc(seq_pc), .br_pc(br_pc), .jmp_pc(jmp_pc), .reg_pc(reg_target),
    .br_eq(br_eq), .alu_zero(alu_zero), .jump_abs(jump_abs),
    .jump_reg(jump_reg), .br_taken(br_taken), .nxt_pc(nxt_pc)
  );

  pc_fetch_regs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst(rst), .en(fetch_en), .nxt_pc(nxt_pc),
    .word(imem_rdata), .pc_q(pc_q), .ir_q(instr_q)
  );

  assign imem_addr = pc_q;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    fetch_en && !br_eq && !jump_abs && !jump_reg |=> imem_addr == $past(imem_addr) + XLEN'(4)); // R3
  AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    fetch_en && !br_taken && !jump_abs && !jump_reg |=> imem_addr == $past(imem_addr) + XLEN'(4)); // R5
  AST_REG_JUMP: assert property (@(posedge clk) disable iff (rst)
    fetch_en && jump_reg |=> imem_addr == $past(reg_target)); // R7
  AST_JUMP_OVER_BRANCH: assert property (@(posedge clk) disable iff (rst)
    fetch_en && jump_abs && !jump_reg |=>
      imem_addr[JFLD_W+1:0] == {$past(imem_rdata[JFLD_W-1:0]), 2'b00}); // R8
endmodule

// File: tb/fetch_pc_unit_bench.sv
module fetch_pc_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_en = 1'b0, br_eq = 1'b0, alu_zero = 1'b0;
  logic        jump_abs = 1'b0, jump_reg = 1'b0;
  logic [31:0] reg_target = '0, imem_rdata, imem_addr, instr_q;
  logic        ov_en = 1'b0;
  logic [31:0] ov_word = '0;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [31:0] m_pc = '0, m_ir = '0;

  always #2 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  always_comb imem_rdata = ov_en ? ov_word : mem_word(imem_addr);

  fetch_pc_unit u_fetch_pc_unit (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .br_eq(br_eq),
    .alu_zero(alu_zero), .jump_abs(jump_abs), .jump_reg(jump_reg),
    .reg_target(reg_target), .imem_rdata(imem_rdata),
    .imem_addr(imem_addr), .instr_q(instr_q)
  );

  task automatic compare(input string tag);
    vectors++;
    if (imem_addr !== m_pc) begin
      miscompares++;
      $display("FAIL %s / R10 pc: actual %h expected %h", tag, imem_addr, m_pc);
    end
    vectors++;
    if (instr_q !== m_ir) begin
      miscompares++;
      $display("FAIL %s / R9 instr: actual %h expected %h", tag, instr_q, m_ir);
    end
  endtask

  // inputs are applied at a falling edge; result checked at the next falling edge
  task automatic step(input logic r, input logic e, input logic b, input logic z,
                      input logic j, input logic jr, input logic [31:0] tgt,
                      input logic use_ov, input logic [31:0] ov, input string tag);
    logic [31:0] w, p4;
    longint off;
    rst = r; fetch_en = e; br_eq = b; alu_zero = z; jump_abs = j; jump_reg = jr;
    reg_target = tgt; ov_en = use_ov; ov_word = ov;
    w = use_ov ? ov : mem_word(m_pc);
    if (r) begin
      m_pc = 0; m_ir = 0;
    end else if (e) begin
      m_ir = w;
      p4 = m_pc + 32'd4;
      off = longint'($signed(w[15:0]));
      if (jr)          m_pc = tgt;
      else if (j)      m_pc = (p4 & 32'hF000_0000) | ((w & 32'h03FF_FFFF) << 2);
      else if (b && z) m_pc = 32'(longint'(p4) + off * 4);
      else             m_pc = p4;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    compare("R1 reset");
    step(0,1,0,0,0,0,0,0,0,"R3 seq");
    step(0,1,0,0,0,0,0,0,0,"R3 seq");
    step(0,1,0,1,0,0,0,0,0,"R3 zero only");
    step(0,1,1,1,0,0,0,1,32'h1000_0005,"R4 forward");
    step(0,1,1,1,0,0,0,1,32'h1000_FFFE,"R4 backward");
    step(0,1,1,1,0,0,0,1,32'h0000_8000,"R4 most negative");
    step(0,1,1,0,0,0,0,1,32'h1000_0005,"R5 zero low");
    step(0,1,0,1,0,0,0,1,32'h1000_0005,"R5 beq low");
    step(0,1,0,0,0,1,32'h0FFF_FFFC,0,0,"R7 reg jump");
    step(0,1,0,0,1,0,0,1,32'h0800_0010,"R6 region edge");
    step(0,1,0,0,1,0,0,1,32'hFC00_0003,"R6 jump");
    step(0,1,1,1,1,1,32'h2000_0100,1,32'h0800_0010,"R8 reg wins");
    step(0,1,1,1,1,0,0,1,32'h0000_0040,"R8 jump beats branch");
    step(0,1,1,1,0,0,0,1,32'h0000_0002,"R8 branch beats seq");
    step(0,0,1,1,1,1,32'h1234_5678,0,0,"R2 stall");
    step(0,0,0,0,0,0,0,0,0,"R2 stall");
    step(1,1,0,0,1,0,0,0,0,"R1 mid reset");
    step(0,1,0,0,0,0,0,0,0,"R3 after reset");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(0, rv[3:0] != 0, rv[4], rv[5], rv[7:6] == 0, rv[9:8] == 0,
           $urandom & 32'hFFFF_FFFC, 0, 0, "R3/R4/R5/R6/R7/R8 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule